// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for a four-beat burst into a synchronous cache memory. A burst begins when a start strobe is seen on a rising clock edge. The full address bus is then captured. After that, the block generates each following beat address itself, changing only the low bits. The upper bits stay fixed for the whole burst, so all beats fall inside one aligned group of four words.

There are two start strobes. One comes from the processor and counts only while the primary chip enable is high. The other comes from the cache controller and always counts. An advance input steps the burst forward by one beat on the edges where it is high.

An order input picks the beat order: interleaved (the start offset XOR the beat number) or linear (the start offset plus the beat number, wrapping within the group). This input is sampled only when a burst starts.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, and after its release until the first start, addr_o is all zeros.
- R2: On an edge where a start is recognised, addr_o shows the complete addr_i sampled at that edge from the next cycle on. The beat number restarts at 0.
- R3: When order_i was 0 at the start, the low BEAT_W bits on beat n are (start low bits + n) mod 2^BEAT_W (linear wrap).
- R4: When order_i was 1 at the start, the low BEAT_W bits on beat n are start low bits XOR n (interleaved).
- R5: An edge with advance_i high and no start moves to the next beat and leaves the upper address bits unchanged. After four advances the address returns to the start address.
- R6: An edge with no start and advance_i low leaves addr_o unchanged.
- R7: proc_stb_i has no effect while cen_i is low: addr_o holds, or only advances if advance_i is high. ctrl_stb_i starts a burst whatever the level of cen_i.
- R8: A start in the middle of a burst reloads the address and restarts the beat count. A start takes precedence over advance_i on the same edge.
- R9: When both strobes are recognised on one edge, exactly one start takes place, loading addr_i with beat 0. The processor strobe has priority.
- R10: order_i is used only on start edges. Changing it in the middle of a burst does not alter the order of the following beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Start address bus |
| proc_stb_i | input | 1 | Processor start strobe, qualified by cen_i |
| ctrl_stb_i | input | 1 | Controller start strobe |
| cen_i | input | 1 | Primary chip enable, high = enabled |
| advance_i | input | 1 | Step to next beat |
| order_i | input | 1 | Burst order at start: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current beat address: held upper bits and sequenced low bits |

## Verification
The bench builds the block with ADDR_W = 10 and the default BEAT_W = 2. With these values, every start offset can be reached within short bursts, and distinct upper-bit patterns show that advancing never touches the upper bits. It drives bursts in both orders starting from odd and even offsets, and runs each through a full wrap. It also covers:
- an order change in the middle of a burst;
- gated and ungated processor strobes;
- a restart in the middle of a burst;
- both strobes asserted together.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bseq_start_arb.sv
module bseq_start_arb (
  input  logic proc_stb_i,
  input  logic ctrl_stb_i,
  input  logic cen_i,
  output logic start_o
);
  logic proc_ok;

  // processor path checked first; either path yields the same single load
  always_comb begin
    proc_ok = proc_stb_i & cen_i;
    if (proc_ok)         start_o = 1'b1;
    else if (ctrl_stb_i) start_o = 1'b1;
    else                 start_o = 1'b0;
  end
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_o <= '0;
    else if (clear_i) beat_o <= '0;
    else if (step_i)  beat_o <= beat_o + ONE; // natural wrap
  end
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import bseq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] base_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  order_e            order_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] lin_w;
  logic [BEAT_W-1:0] ilv_w;

  assign lin_w = base_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_w[b] = base_i[b] ^ beat_i[b];
  end

  assign low_o = (order_i == ORD_INTERLEAVE) ? ilv_w : lin_w;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_stb_i,
  input  logic              ctrl_stb_i,
  input  logic              cen_i,
  input  logic              advance_i,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic              start;
  logic [UP_W-1:0]   upper_q;
  logic [BEAT_W-1:0] base_q;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low;
  order_e            order_q;

  bseq_start_arb u_arb (
    .proc_stb_i (proc_stb_i),
    .ctrl_stb_i (ctrl_stb_i),
    .cen_i      (cen_i),
    .start_o    (start)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q <= '0;
      base_q  <= '0;
      order_q <= ORD_LINEAR;
    end else if (start) begin
      upper_q <= addr_i[ADDR_W-1:BEAT_W];
      base_q  <= addr_i[BEAT_W-1:0];
      order_q <= order_e'(order_i);
    end
  end

  bseq_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start),
    .step_i  (advance_i),
    .beat_o  (beat)
  );

  bseq_order_map #(.BEAT_W(BEAT_W)) u_map (
    .base_i  (base_q),
    .beat_i  (beat),
    .order_i (order_q),
    .low_o   (low)
  );

  assign addr_o = {upper_q, low};
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              proc_stb_i,
  input logic              ctrl_stb_i,
  input logic              cen_i,
  input logic              advance_i,
  input logic              order_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic go;
  assign go = ctrl_stb_i | (proc_stb_i & cen_i);

  always_comb begin
    if (!rst_ni) assert_reset_zero_R1: assert (addr_o == '0);
  end

  assert_start_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> addr_o == $past(addr_i));

  assert_advance_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!go && advance_i) |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]))
                           && (addr_o[BEAT_W-1:0] != $past(addr_o[BEAT_W-1:0])));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!go && !advance_i) |=> $stable(addr_o));

  assert_proc_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_stb_i && !cen_i && !ctrl_stb_i && !advance_i) |=> $stable(addr_o));
endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int ADDR_W = 10;
  localparam int BEAT_W = 2;
  localparam int UP_W   = ADDR_W - BEAT_W;

  typedef struct {
    logic [ADDR_W-1:0] exp;
    string             req;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              ps = 1'b0, cs = 1'b0, ce = 1'b0, adv = 1'b0, ord = 1'b0;
  logic [ADDR_W-1:0] addr_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  item_t sb[$];

  logic [UP_W-1:0]   m_up   = '0;
  logic [BEAT_W-1:0] m_base = '0;
  logic [BEAT_W-1:0] m_beat = '0;
  logic              m_ord  = 1'b0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .proc_stb_i(ps),
    .ctrl_stb_i(cs), .cen_i(ce), .advance_i(adv), .order_i(ord), .addr_o(addr_out)
  );

  task automatic check(input logic [ADDR_W-1:0] got, input logic [ADDR_W-1:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: addr_o got %h expected %h", req, got, exp);
    end
  endtask

  // driver: set inputs away from the edge and push the model's next address
  task automatic step(input logic [ADDR_W-1:0] a, input logic p, input logic c,
                      input logic e, input logic v, input logic o, input string req);
    logic st;
    logic [BEAT_W-1:0] lo;
    item_t it;
    @(negedge clk);
    addr = a; ps = p; cs = c; ce = e; adv = v; ord = o;
    st = c | (p & e);
    if (st) begin
      m_up = a[ADDR_W-1:BEAT_W]; m_base = a[BEAT_W-1:0]; m_beat = '0; m_ord = o;
    end else if (v) begin
      m_beat = m_beat + 1'b1;
    end
    lo = m_ord ? (m_base ^ m_beat) : (m_base + m_beat);
    it.exp = {m_up, lo};
    it.req = req;
    sb.push_back(it);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(addr_out, it.exp, it.req);
    end
  end

  initial begin
    #25;
    check(addr_out, '0, "R1");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(addr_out, '0, "R1");

    // linear burst from offset 1, full wrap
    step(10'h2A5, 0, 1, 1, 0, 0, "R2");
    step(10'h000, 0, 0, 1, 1, 0, "R3");
    step(10'h000, 0, 0, 1, 1, 0, "R3");
    step(10'h000, 0, 0, 1, 1, 0, "R3");
    step(10'h000, 0, 0, 1, 1, 0, "R5");
    step(10'h3FF, 0, 0, 1, 0, 1, "R6");
    step(10'h155, 0, 0, 0, 0, 0, "R6");

    // interleaved burst from offset 2, order input flipped mid-burst
    step(10'h13E, 1, 0, 1, 0, 1, "R2");
    step(10'h000, 0, 0, 1, 1, 0, "R4");
    step(10'h000, 0, 0, 1, 1, 0, "R10");
    step(10'h000, 0, 0, 1, 1, 1, "R4");
    step(10'h000, 0, 0, 1, 1, 0, "R5");

    // interleaved from offset 3
    step(10'h0C7, 0, 1, 0, 0, 1, "R7");
    step(10'h000, 0, 0, 1, 1, 1, "R4");
    step(10'h000, 0, 0, 1, 1, 1, "R4");

    // gated processor strobe
    step(10'h3A0, 1, 0, 0, 0, 0, "R7");
    step(10'h3A0, 1, 0, 0, 1, 0, "R7");

    // restart mid-burst with advance on the same edge
    step(10'h21A, 0, 1, 1, 1, 0, "R8");
    step(10'h000, 0, 0, 1, 1, 0, "R3");
    step(10'h09D, 1, 0, 1, 1, 0, "R8");
    step(10'h000, 0, 0, 1, 1, 0, "R3");

    // both strobes together
    step(10'h2F2, 1, 1, 1, 0, 1, "R9");
    step(10'h000, 0, 0, 1, 1, 1, "R9");
    step(10'h000, 0, 0, 1, 0, 0, "R6");

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule